// File: doc/BRIEF.md
# Entropy Bit Collector with Masked Control Register

This block turns a raw one-bit entropy stream into words that software can read. The stream comes from oscillator rings outside the block. Software works through a small 32-bit register port. It programs a sampling interval, picks one of four rings, and chooses a collection length between 64 and 256 bits. It then raises a start bit. The block samples the entropy input once per interval and packs the bits into eight 32-bit result words. When the requested count is reached, it drops the start bit, and software polls for that.

The control register uses write masks in its upper half-word. Because of this, software can change single fields without first reading the register. While a collection is pending, the result words read as zero, so software never sees a partly filled word.

Top module: `trng_collector`

## Requirements
- R1: After reset, the control register (offset 0x400), the sample-count register (0x404), every result word and `ring_sel` all read 0.
- R2: A write to 0x400 changes control bit k (k = 0..15) only where write-data bit 16+k is 1. Bits [31:16] of the control register read as 0. Field layout: bit 0 is START, bit 1 is ENABLE, bits [3:2] are the ring select (driven on `ring_sel`), and bits [5:4] are the length code.
- R3: The sample-count register at 0x404 sets the interval N in clock cycles, and a value of 0 acts as 1. Sample k (k = 1, 2, ...) is taken on the k·N-th rising edge after the edge that accepted the START write.
- R4: No sample is taken unless START and ENABLE are both 1. With START=1 and ENABLE=0, START stays 1 indefinitely.
- R5: Sample i (counting from 0) is stored at bit i%32 of the result word at offset 0x410 + 4·(i/32).
- R6: Length code L selects 64·(L+1) bits. START reads 1 before the clock edge that stores the last bit and reads 0 from that edge on.
- R7: Result words with an index of 2·(L+1) or more read as 0.
- R8: While START is 1, every result word reads 0. A write that takes START from 0 to 1 clears all stored result bits.
- R9: A write to 0x404 is ignored while START and ENABLE are both 1.
- R10: Writing 0xFFFF0000 to 0x400 zeroes the control field. This stops any collection, and START then stays 0.
- R11: Reads of any offset other than 0x400, 0x404 and the eight result words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (12) | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| ent_bit | input | 1 | Entropy bit, already synchronised to `clk` |
| ring_sel | output | 2 | Selected oscillator ring, 0 fastest to 3 slowest |

## Verification
The assertions assume that `ent_bit` is already synchronous to `clk`. They also assume that each write lasts exactly one cycle and that reads have no side effects. The bench drives `ent_bit` as a fixed hash of its own cycle count. It changes writes only on falling edges and holds `bus_wr` high for a single cycle. This lets it predict exactly which value each sample captures. Collections are run for each length code and at several intervals, including an interval of 0. The bench also covers a stop issued mid-collection and a START with ENABLE low.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned OFS_CTRL = 32'h400;
  localparam int unsigned OFS_SCNT = 32'h404;
  localparam int unsigned OFS_DATA = 32'h410;

  typedef struct packed {
    logic [9:0] spare;
    logic [1:0] len;
    logic [1:0] ring;
    logic       en;
    logic       start;
  } ctrl_t;
endpackage

// File: rtl/trng_ctrl_reg.sv
module trng_ctrl_reg
  import trng_pkg::*;
#(
  parameter int SCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_scnt,
  input  logic [31:0]    wdata,
  input  logic           done,
  output ctrl_t          ctrl_q,
  output logic [SCW-1:0] scnt_q,
  output logic           arm
);
  ctrl_t          base;
  logic [15:0]    base_v;
  logic [15:0]    msk;
  logic [15:0]    ctrl_d;
  logic           ctrl_ce;
  logic           scnt_ce;
  logic           running;

  assign running = ctrl_q.start & ctrl_q.en;
  assign msk     = wdata[31:16];

  always_comb begin
    base = ctrl_q;
    if (done) base.start = 1'b0;
    base_v  = base;
    ctrl_d  = base_v;
    if (wr_ctrl) ctrl_d = (base_v & ~msk) | (wdata[15:0] & msk);
    ctrl_ce = wr_ctrl | done;
    arm     = wr_ctrl & msk[0] & wdata[0] & ~base.start;
    scnt_ce = wr_scnt & ~running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      scnt_q <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_t'(ctrl_d);
      if (scnt_ce) scnt_q <= wdata[SCW-1:0];
    end
  end
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
  parameter int SCW   = 16,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             arm,
  input  logic [SCW-1:0]   scnt,
  input  logic [IDX_W-1:0] len_bits,
  output logic             take,
  output logic [IDX_W-1:0] idx_q,
  output logic             done
);
  logic [SCW-1:0]   period;
  logic [SCW-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W:0]   idx_next;

  always_comb begin
    period   = (scnt == '0) ? SCW'(1) : scnt;
    take     = run && (cnt_q == period - SCW'(1));
    idx_next = {1'b0, idx_q} + (IDX_W+1)'(1);
    done     = take && (idx_next >= {1'b0, len_bits});
    if (arm || !run || take) cnt_d = '0;
    else                     cnt_d = cnt_q + SCW'(1);
    if (arm)       idx_d = '0;
    else if (take) idx_d = idx_next[IDX_W-1:0];
    else           idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (arm || take) idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/trng_store.sv
module trng_store #(
  parameter int NW    = 8,
  parameter int WW    = 32,
  parameter int IDX_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  take,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  bit_in,
  output logic [NW-1:0][WW-1:0] words_q
);
  localparam int OFF_W = $clog2(WW);

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic          hit;
    logic          ce;
    logic [WW-1:0] word_d;

    assign hit = take && (idx[IDX_W-1:OFF_W] == (IDX_W-OFF_W)'(w));
    assign ce  = clr | hit;

    always_comb begin
      word_d = words_q[w];
      if (clr)      word_d = '0;
      else if (hit) word_d[idx[OFF_W-1:0]] = bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  words_q[w] <= '0;
      else if (ce) words_q[w] <= word_d;
    end
  end
endmodule

// File: rtl/trng_collector.sv
module trng_collector
  import trng_pkg::*;
#(
  parameter int NW  = 8,
  parameter int SCW = 16,
  parameter int AW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ent_bit,
  output logic [1:0]    ring_sel
);
  localparam int WW       = 32;
  localparam int MAXB     = NW * WW;
  localparam int IDX_W    = $clog2(MAXB) + 1;
  localparam int LEN_UNIT = MAXB / 4;
  localparam int WSEL_W   = $clog2(NW);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_SCNT = AW'(OFS_SCNT);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);

  ctrl_t                 ctrl_q;
  logic [SCW-1:0]        scnt_q;
  logic                  arm, take, done, run;
  logic [IDX_W-1:0]      idx_q, len_bits, vis_words;
  logic [NW-1:0][WW-1:0] words_q;
  logic [AW-1:0]         off;
  logic                  in_data;
  logic [WSEL_W-1:0]     wsel;

  assign run      = ctrl_q.start & ctrl_q.en;
  assign ring_sel = ctrl_q.ring;
  assign len_bits = (IDX_W'(ctrl_q.len) + IDX_W'(1)) * IDX_W'(LEN_UNIT);
  assign vis_words = len_bits / IDX_W'(WW);

  trng_ctrl_reg #(.SCW(SCW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(bus_wr && bus_addr == A_CTRL),
    .wr_scnt(bus_wr && bus_addr == A_SCNT),
    .wdata(bus_wdata), .done(done),
    .ctrl_q(ctrl_q), .scnt_q(scnt_q), .arm(arm)
  );

  trng_sampler #(.SCW(SCW), .IDX_W(IDX_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .run(run), .arm(arm),
    .scnt(scnt_q), .len_bits(len_bits),
    .take(take), .idx_q(idx_q), .done(done)
  );

  trng_store #(.NW(NW), .WW(WW), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(arm), .take(take),
    .idx(idx_q), .bit_in(ent_bit), .words_q(words_q)
  );

  always_comb begin
    off       = bus_addr - A_DATA;
    in_data   = (bus_addr >= A_DATA) && (off < AW'(NW * 4)) && (off[1:0] == 2'b00);
    wsel      = off[WSEL_W+1:2];
    bus_rdata = '0;
    if (bus_addr == A_CTRL)      bus_rdata = {16'h0000, ctrl_q};
    else if (bus_addr == A_SCNT) bus_rdata = 32'(scnt_q);
    else if (in_data && !ctrl_q.start && (IDX_W'(wsel) < vis_words))
      bus_rdata = words_q[wsel];
  end
endmodule

// File: rtl/trng_collector_chk.sv
module trng_collector_chk
  import trng_pkg::*;
#(
  parameter int AW    = 12,
  parameter int SCW   = 16,
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [1:0]       ring_sel,
  input logic [15:0]      ctrl_v,
  input logic [SCW-1:0]   scnt_q,
  input logic [IDX_W-1:0] idx_q
);
  logic ctrl_wr, scnt_wr, active;
  assign ctrl_wr = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign scnt_wr = bus_wr && (bus_addr == AW'(OFS_SCNT));
  assign active  = ctrl_v[0] & ctrl_v[1];

  assert_ring_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ring_sel));

  assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_v[0]) |-> $past(ctrl_wr && bus_wdata[16] && bus_wdata[0]));

  assert_idle_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ctrl_wr) |=> $stable(idx_q));

  assert_scnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && scnt_wr) |=> $stable(scnt_q));

  assert_full_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata == 32'hFFFF_0000) |=> (ctrl_v == 16'h0000));
endmodule

bind trng_collector trng_collector_chk #(.AW(AW), .SCW(SCW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ring_sel(ring_sel), .ctrl_v(ctrl_q),
  .scnt_q(scnt_q), .idx_q(idx_q)
);

// File: tb/sim_trng_collector.sv
module sim_trng_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_bit;
  logic [1:0]  ring_sel;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    logic [11:0] addr;
  } rd_item_t;
  rd_item_t rq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic ent_of(int c);
    int h;
    h = c * 1103515245 + 12345;
    return h[16] ^ h[9];
  endfunction
  assign ent_bit = ent_of(cyc);

  trng_collector u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_bit(ent_bit),
    .ring_sel(ring_sel)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops expected read values and compares with the port.
  always @(negedge clk) begin
    rd_item_t it;
    #2;
    if (rq.size() > 0) begin
      it = rq.pop_front();
      chk(bus_rdata, it.exp, it.tag);
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    it.exp = e; it.tag = tag; it.addr = a;
    rq.push_back(it);
  endtask

  function automatic logic [31:0] exp_word(int c0, int n, int nbits, int w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      int i;
      i = w * 32 + b;
      if (i < nbits) r[b] = ent_of(c0 + (i + 1) * n);
    end
    return r;
  endfunction

  task automatic wait_cyc(input int tgt);
    while (cyc < tgt) @(negedge clk);
  endtask

  task automatic check_words(input int c0, input int n, input int nbits, input string tag);
    for (int w = 0; w < 8; w++)
      expect_rd(12'h410 + 12'(4 * w), exp_word(c0, n, nbits, w), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(12'h400, 32'h0, "R1 ctrl");
    expect_rd(12'h404, 32'h0, "R1 scnt");
    expect_rd(12'h410, 32'h0, "R1 word0");
    @(negedge clk);
    chk(32'(ring_sel), 32'h0, "R1 ring_sel");

    // R2 masked writes
    bus_write(12'h400, 32'h000C_0008);
    expect_rd(12'h400, 32'h0000_0008, "R2 ring field");
    chk(32'(ring_sel), 32'h2, "R2 ring_sel");
    bus_write(12'h400, 32'h0000_FFFF);
    expect_rd(12'h400, 32'h0000_0008, "R2 zero mask");

    // R3 R5 R6 R7 R8: 64 bits, interval 3
    bus_write(12'h404, 32'd3);
    expect_rd(12'h404, 32'd3, "R3 scnt readback");
    bus_write(12'h400, 32'h003F_0007);
    c0 = cyc - 1;
    expect_rd(12'h410, 32'h0, "R8 hidden while running");
    wait_cyc(c0 + 64 * 3 - 1);
    expect_rd(12'h400, 32'h0000_0007, "R6 start before last bit");
    expect_rd(12'h400, 32'h0000_0006, "R6 start cleared");
    check_words(c0, 3, 64, "R5 R7 len64");

    // R9: 256 bits, interval 1, scnt write ignored while running
    bus_write(12'h404, 32'd1);
    bus_write(12'h400, 32'h003F_003F);
    c0 = cyc - 1;
    bus_write(12'h404, 32'd50);
    wait_cyc(c0 + 256 + 3);
    expect_rd(12'h400, 32'h0000_003E, "R6 len256 done");
    expect_rd(12'h404, 32'd1, "R9 scnt unchanged");
    check_words(c0, 1, 256, "R5 len256");

    // R3 zero interval acts as one, 128 bits
    bus_write(12'h404, 32'd0);
    bus_write(12'h400, 32'h003F_0017);
    c0 = cyc - 1;
    wait_cyc(c0 + 128 + 3);
    expect_rd(12'h400, 32'h0000_0016, "R6 len128 done");
    expect_rd(12'h404, 32'd0, "R3 zero stored");
    check_words(c0, 1, 128, "R3 R7 len128");

    // R4 start without enable; R8 clear on start; R10 stop
    bus_write(12'h404, 32'd2);
    bus_write(12'h400, 32'h003F_0001);
    wait_cyc(cyc + 100);
    expect_rd(12'h400, 32'h0000_0001, "R4 no run without enable");
    expect_rd(12'h410, 32'h0, "R8 hidden while start");
    bus_write(12'h400, 32'hFFFF_0000);
    expect_rd(12'h400, 32'h0, "R10 stop");
    expect_rd(12'h410, 32'h0, "R8 old data cleared w0");
    expect_rd(12'h414, 32'h0, "R8 old data cleared w1");

    // R10 stop mid collection
    bus_write(12'h400, 32'hFFFF_003B);
    wait_cyc(cyc + 20);
    bus_write(12'h400, 32'hFFFF_0000);
    wait_cyc(cyc + 10);
    expect_rd(12'h400, 32'h0, "R10 stopped mid run");
    wait_cyc(cyc + 300);
    expect_rd(12'h400, 32'h0, "R10 stays stopped");

    // R11 undefined offsets and upper half
    bus_write(12'h400, 32'hFFFF_FFC0);
    expect_rd(12'h400, 32'h0000_FFC0, "R11 ctrl upper zero");
    expect_rd(12'h408, 32'h0, "R11 gap 0x408");
    expect_rd(12'h40C, 32'h0, "R11 gap 0x40C");
    expect_rd(12'h430, 32'h0, "R11 past data");
    expect_rd(12'h000, 32'h0, "R11 base");
    expect_rd(12'h412, 32'h0, "R11 unaligned");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule